// File: doc/BRIEF.md
# Fractional T1/E1 Gapped Channel Clock

This block turns a continuous line bit clock into a gapped clock that pulses only during the bits of chosen timeslots. A serial controller that knows nothing about framing can then capture just those timeslots. A frame sync pulse marks the first bit of each frame. A position counter follows the frame and free-runs between sync pulses. A per-channel mask selects the timeslots that are clocked. A 56 kbit/s option drops the final bit of every selected slot. In T1 framing, no pulse is produced at the framing bit.

The gating enable is registered on the falling edge of the bit clock and ANDed with the bit clock, so the output never glitches. A matching single-cycle enable strobe, registered on the rising edge, serves logic that stays synchronous to the bit clock. The mask, framing kind and rate are captured only when a new frame begins, so a frame is never gated by a mix of two settings. The receive path and the transmit path each use their own instance with their own controls.

Timing convention: a sync sampled high at a rising edge makes the bit period that starts at that edge position 0. The output for position p appears in the bit period that follows, with `bit_en` high for that whole period and `gap_clk` high during its high phase.

Top module: `frac_chan_clk`

## Requirements
- R1: A bit is clocked (a `gap_clk` pulse and `bit_en` high, one bit period after its position) only when its channel's mask bit is set. In E1 framing, channel c occupies positions 8c to 8c+7. In T1 framing, it occupies positions 1+8c to 8+8c.
- R2: While `enable` is low, `gap_clk` stays low, and `bit_en` is low in the following bit period.
- R3: In T1 framing, position 0 (the framing bit) is never clocked.
- R4: With `rate_56k` high, the last bit of each slot (slot bit 7, bits sent MSB first from slot bit 0) is never clocked.
- R5: Without sync, the position counter advances by one per bit and wraps after 193 positions in T1 framing and 256 positions in E1 framing.
- R6: A sync sampled high forces position 0 for the bit period that starts at that edge, even mid-frame.
- R7: `chan_mask`, `t1_mode` and `rate_56k` are sampled only at the edge that begins a new frame, whether by sync or by wrap. Changes made in between have no effect until then.
- R8: `gap_clk` is low throughout the low phase of `bit_clk`.
- R9: A frame that runs whole with `enable` high yields 8 pulses per selected channel, or 7 pulses per selected channel at 56k.
- R10: During and after reset, both outputs are low. The captured setting resets to E1 framing with an empty mask, so nothing is clocked until the first frame start.
- R11: In T1 framing, mask bits 24 to 31 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | High for the first bit of a frame |
| t1_mode | input | 1 | 1 = T1 framing (193 bits), 0 = E1 framing (256 bits) |
| rate_56k | input | 1 | 1 = drop the last bit of each slot |
| enable | input | 1 | Gating enable for this instance |
| chan_mask | input | 32 | Channel selection, bit c selects channel c |
| gap_clk | output | 1 | Gapped clock |
| bit_en | output | 1 | Registered per-bit enable strobe |

## Verification
Two events can land on the same edge: a frame start (by sync or by wrap) and a change of mask, framing kind or rate. The bench changes the setting in the bit period just before a sync or a wrap, and also in the middle of a frame. A cycle-accurate model that captures the setting only at frame starts then decides, bit by bit, whether the new or the old setting must apply. A mid-frame sync that lands on the same edge as a pending setting change shows whether the capture follows the sync rather than the natural wrap.

// File: rtl/fcg_pkg.sv
`timescale 1ns/1ps
package fcg_pkg;
   typedef enum logic {
      KIND_E1 = 1'b0,
      KIND_T1 = 1'b1
   } frame_kind_e;
endpackage

// File: rtl/fcg_ctrl_shadow.sv
`timescale 1ns/1ps
module fcg_ctrl_shadow
   import fcg_pkg::*;
#(
   parameter int unsigned MASK_W     = 32,
   parameter bit          SUPPORT_T1 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              t1_in,
   input  logic              rate_in,
   input  logic [MASK_W-1:0] mask_in,
   output frame_kind_e       kind_q,
   output logic              rate_q,
   output logic [MASK_W-1:0] mask_q
);
   frame_kind_e kind_in;

   generate
      if (SUPPORT_T1) begin : g_kind_sel
         assign kind_in = t1_in ? KIND_T1 : KIND_E1;
      end else begin : g_kind_fixed
         logic unused_t1;
         assign unused_t1 = t1_in;
         assign kind_in   = KIND_E1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= KIND_E1;
         rate_q <= 1'b0;
         mask_q <= '0;
      end else if (load) begin
         kind_q <= kind_in;
         rate_q <= rate_in;
         mask_q <= mask_in;
      end
   end

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(mask_q) && $stable(rate_q) && $stable(kind_q))); // R7
endmodule

// File: rtl/fcg_pos_counter.sv
`timescale 1ns/1ps
module fcg_pos_counter
   import fcg_pkg::*;
#(
   parameter int unsigned POS_W  = 8,
   parameter int unsigned T1_LEN = 193,
   parameter int unsigned E1_LEN = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync,
   input  frame_kind_e      kind,
   output logic [POS_W-1:0] pos_q,
   output logic             frame_start
);
   localparam logic [POS_W-1:0] T1_LAST = POS_W'(T1_LEN - 1);
   localparam logic [POS_W-1:0] E1_LAST = POS_W'(E1_LEN - 1);

   logic [POS_W-1:0] last_pos;
   logic             at_end;

   assign last_pos    = (kind == KIND_T1) ? T1_LAST : E1_LAST;
   assign at_end      = (pos_q >= last_pos);
   assign frame_start = sync | at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pos_q <= '0;
      else if (frame_start) pos_q <= '0;
      else                 pos_q <= pos_q + POS_W'(1);
   end

   AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      sync |=> (pos_q == '0)); // R6
   AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync && pos_q < last_pos) |=> (pos_q == $past(pos_q) + POS_W'(1))); // R5
   AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync && pos_q == last_pos) |=> (pos_q == '0)); // R5
endmodule

// File: rtl/fcg_slot_decode.sv
`timescale 1ns/1ps
module fcg_slot_decode
   import fcg_pkg::*;
#(
   parameter int unsigned POS_W      = 8,
   parameter int unsigned MASK_W     = 32,
   parameter int unsigned SLOT_BITS  = 8,
   parameter int unsigned T1_FBITS   = 1,
   parameter bit          SUPPORT_T1 = 1'b1,
   localparam int unsigned CH_W      = (MASK_W > 1) ? $clog2(MASK_W) : 1,
   localparam int unsigned BIT_W     = $clog2(SLOT_BITS)
) (
   input  frame_kind_e       kind,
   input  logic              rate56,
   input  logic [MASK_W-1:0] mask,
   input  logic [POS_W-1:0]  pos,
   output logic              fbit,
   output logic [CH_W-1:0]   chan,
   output logic [BIT_W-1:0]  slot_bit,
   output logic              sel
);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

   logic [POS_W-1:0] rel;

   generate
      if (SUPPORT_T1) begin : g_t1_offset
         assign fbit = (kind == KIND_T1) && (pos < POS_W'(T1_FBITS));
         assign rel  = ((kind == KIND_T1) && !fbit) ? pos - POS_W'(T1_FBITS) : pos;
      end else begin : g_e1_only
         frame_kind_e unused_kind;
         assign unused_kind = kind;
         assign fbit        = 1'b0;
         assign rel         = pos;
      end
   endgenerate

   assign chan     = CH_W'(rel / POS_W'(SLOT_BITS));
   assign slot_bit = BIT_W'(rel % POS_W'(SLOT_BITS));
   assign sel      = !fbit && mask[chan] && !(rate56 && slot_bit == LAST_BIT);
endmodule

// File: rtl/fcg_gate_out.sv
`timescale 1ns/1ps
module fcg_gate_out (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic enable,
   output logic gap_clk,
   output logic bit_en
);
   logic gate_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= sel & enable;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_en <= 1'b0;
      else        bit_en <= sel & enable;
   end

   assign gap_clk = clk & gate_q;

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !bit_en); // R2
endmodule

// File: rtl/frac_chan_clk.sv
`timescale 1ns/1ps
module frac_chan_clk
   import fcg_pkg::*;
#(
   parameter int unsigned T1_CHANNELS = 24,
   parameter int unsigned E1_SLOTS    = 32,
   parameter int unsigned SLOT_BITS   = 8,
   parameter int unsigned T1_FBITS    = 1,
   parameter int unsigned MASK_W      = 32,
   parameter bit          SUPPORT_T1  = 1'b1
) (
   input  logic              bit_clk,
   input  logic              rst_n,
   input  logic              frame_sync,
   input  logic              t1_mode,
   input  logic              rate_56k,
   input  logic              enable,
   input  logic [MASK_W-1:0] chan_mask,
   output logic              gap_clk,
   output logic              bit_en
);
   localparam int unsigned T1_LEN  = T1_FBITS + T1_CHANNELS * SLOT_BITS;
   localparam int unsigned E1_LEN  = E1_SLOTS * SLOT_BITS;
   localparam int unsigned MAX_LEN = (T1_LEN > E1_LEN) ? T1_LEN : E1_LEN;
   localparam int unsigned POS_W   = $clog2(MAX_LEN);
   localparam int unsigned CH_W    = (MASK_W > 1) ? $clog2(MASK_W) : 1;
   localparam int unsigned BIT_W   = $clog2(SLOT_BITS);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

   generate
      if (SLOT_BITS < 2 || (SLOT_BITS & (SLOT_BITS - 1)) != 0) begin : g_bad_slot
         $error("SLOT_BITS must be a power of two of at least 2");
      end
      if (MASK_W < E1_SLOTS || (SUPPORT_T1 && MASK_W < T1_CHANNELS)) begin : g_bad_mask
         $error("MASK_W too narrow for the channel count");
      end
   endgenerate

   frame_kind_e       kind_q;
   logic              rate_q;
   logic [MASK_W-1:0] mask_q;
   logic [POS_W-1:0]  pos_q;
   logic              frame_start;
   logic              fbit;
   logic [CH_W-1:0]   chan;
   logic [BIT_W-1:0]  slot_bit;
   logic              sel;

   fcg_pos_counter #(
      .POS_W (POS_W),
      .T1_LEN(T1_LEN),
      .E1_LEN(E1_LEN)
   ) u_pos (
      .clk        (bit_clk),
      .rst_n      (rst_n),
      .sync       (frame_sync),
      .kind       (kind_q),
      .pos_q      (pos_q),
      .frame_start(frame_start)
   );

   fcg_ctrl_shadow #(
      .MASK_W    (MASK_W),
      .SUPPORT_T1(SUPPORT_T1)
   ) u_shadow (
      .clk    (bit_clk),
      .rst_n  (rst_n),
      .load   (frame_start),
      .t1_in  (t1_mode),
      .rate_in(rate_56k),
      .mask_in(chan_mask),
      .kind_q (kind_q),
      .rate_q (rate_q),
      .mask_q (mask_q)
   );

   fcg_slot_decode #(
      .POS_W     (POS_W),
      .MASK_W    (MASK_W),
      .SLOT_BITS (SLOT_BITS),
      .T1_FBITS  (T1_FBITS),
      .SUPPORT_T1(SUPPORT_T1)
   ) u_dec (
      .kind    (kind_q),
      .rate56  (rate_q),
      .mask    (mask_q),
      .pos     (pos_q),
      .fbit    (fbit),
      .chan    (chan),
      .slot_bit(slot_bit),
      .sel     (sel)
   );

   fcg_gate_out u_gate (
      .clk    (bit_clk),
      .rst_n  (rst_n),
      .sel    (sel),
      .enable (enable),
      .gap_clk(gap_clk),
      .bit_en (bit_en)
   );

   AST_FBIT_SILENT: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (kind_q == KIND_T1 && pos_q == '0) |=> !bit_en); // R3
   AST_LSB_DROP: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (rate_q && slot_bit == LAST_BIT) |=> !bit_en); // R4
   AST_UNSEL_SILENT: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (!mask_q[chan]) |=> !bit_en); // R1
   AST_T1_CHAN_RANGE: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (kind_q == KIND_T1 && !fbit) |-> (chan < CH_W'(T1_CHANNELS))); // R11
endmodule

// File: tb/frac_chan_clk_test.sv
`timescale 1ns/1ps
module frac_chan_clk_test;
   logic        clk = 1'b0;
   logic        rst_n, frame_sync, t1_mode, rate_56k, enable;
   logic [31:0] chan_mask;
   logic        gap_clk, bit_en;

   always #10 clk = ~clk;

   frac_chan_clk uut (
      .bit_clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .t1_mode(t1_mode),
      .rate_56k(rate_56k), .enable(enable), .chan_mask(chan_mask),
      .gap_clk(gap_clk), .bit_en(bit_en)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit mon_on = 0;
   bit finished = 0;

   int          m_pos, m_cnt, m_len;
   bit          m_t1, m_r56, m_clean, m_exp;
   logic [31:0] m_mask;
   string       m_tag;

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit model_sel(bit t1, bit r56, logic [31:0] mask, int pos);
      int rel;
      if (t1) begin
         if (pos == 0) return 1'b0;
         rel = pos - 1;
      end else rel = pos;
      if (!mask[rel / 8]) return 1'b0;
      if (r56 && (rel % 8) == 7) return 1'b0;
      return 1'b1;
   endfunction

   function automatic int model_frame(bit t1, bit r56, logic [31:0] mask);
      int n = 0;
      for (int c = 0; c < (t1 ? 24 : 32); c++)
         if (mask[c]) n += r56 ? 7 : 8;
      return n;
   endfunction

   function automatic string tag_for(bit en, bit t1, bit r56, logic [31:0] mask, int pos);
      int rel;
      if (!en) return "R2";
      if (t1 && pos == 0) return "R3";
      rel = t1 ? pos - 1 : pos;
      if (r56 && (rel % 8) == 7) return "R4";
      if (t1 && mask[31:24] != 0) return "R11";
      return "R1";
   endfunction

   // rising-edge model: judge the period that just ended, then advance
   always @(posedge clk) begin
      #2;
      if (rst_n && mon_on) begin
         m_exp = enable && model_sel(m_t1, m_r56, m_mask, m_pos);
         m_tag = tag_for(enable, m_t1, m_r56, m_mask, m_pos);
         check(m_tag, gap_clk, m_exp);
         check(m_tag, bit_en, m_exp);
         if (gap_clk) m_cnt++;
         if (!enable) m_clean = 0;
         m_len = m_t1 ? 193 : 256;
         if (frame_sync || m_pos == m_len - 1) begin
            if (m_pos == m_len - 1 && m_clean)
               check("R9", m_cnt, model_frame(m_t1, m_r56, m_mask));
            if (frame_sync && m_pos != m_len - 1) m_tag = "R6";
            m_pos   = 0;
            m_t1    = t1_mode;     // R7: capture only at frame start
            m_r56   = rate_56k;
            m_mask  = chan_mask;
            m_cnt   = 0;
            m_clean = 1;
         end else m_pos++;          // R5
      end
   end

   always @(negedge clk) begin
      #2;
      if (rst_n && mon_on) check("R8", gap_clk, 0);
   end

   task automatic step(input int n);
      repeat (n) begin @(posedge clk); #5; end
   endtask

   task automatic pulse_sync();
      frame_sync = 1'b1; step(1); frame_sync = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd2718));
      rst_n = 0; frame_sync = 0; t1_mode = 0; rate_56k = 0; enable = 1;
      chan_mask = '1;
      m_pos = 0; m_t1 = 0; m_r56 = 0; m_mask = '0; m_cnt = 0; m_clean = 0;
      step(3);
      check("R10", gap_clk, 0);
      check("R10", bit_en, 0);
      rst_n = 1; mon_on = 1;
      step(20);                                   // R10: empty mask, no pulses
      check("R10", bit_en, 0);

      // T1, all channels, 64k, then free-run wrap
      t1_mode = 1; chan_mask = '1; pulse_sync(); step(193 * 2 + 10);
      // change to 56k mid-frame: applies at next wrap (R7)
      rate_56k = 1; chan_mask = 32'hFF80_0001; step(193 * 2);
      // E1 pattern, sync, then mid-frame sync (R6)
      t1_mode = 0; rate_56k = 0; chan_mask = 32'hAAAA_5555; pulse_sync(); step(300);
      chan_mask = 32'h0000_FFFF; step(40); pulse_sync(); step(260);
      // enable dropped for part of a frame (R2)
      enable = 0; step(60); enable = 1; step(300);
      // E1 56k full, with setting change just before a sync
      rate_56k = 1; chan_mask = '1; pulse_sync(); step(255);
      chan_mask = 32'h8000_0001; t1_mode = 1; pulse_sync(); step(200);

      for (int i = 0; i < 25; i++) begin
         t1_mode   = $urandom % 2;
         rate_56k  = $urandom % 2;
         chan_mask = $urandom;
         enable    = ($urandom % 5) != 0;
         if ($urandom % 2) pulse_sync();
         step(50 + ($urandom % 400));
      end
      enable = 1; pulse_sync(); step(600);

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule